// File: doc/BRIEF.md
# Vectored Interrupt Controller for an 8-bit Core

This block gathers interrupt requests for a small 8-bit processor and, when one may be serviced, asks the core to branch to that source's fixed vector. There are seven sources: two external pins, two timer overflow pulses, a time-base tick, a real-time-clock tick and an analog-to-digital conversion-done event. The external pins are edge-triggered. Each pin's active edge is chosen at build time.

Software reads and writes two 8-bit control registers. These hold the global enable, one enable per source, and the request flags. The core reports how many return addresses its stack holds. The controller offers a call through a valid/ready pair. The source's flag is cleared, together with the global enable for maskable sources, on the cycle the core accepts. The conversion-done event is non-maskable by the global enable. It has its own enable and is offered even when the stack is full; the core then drops its oldest return address.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset both registers read 0x00 and `call_valid` is low.
- R2: Register 0 bits are: 0 global enable, 1/2/3 enables of ext0/ext1/timer0, 4/5/6 flags of ext0/ext1/timer0, 7 conversion-done enable. Register 1 bits are: 0/1/2 enables of timer1/time-base/RTC, 4/5/6 flags of timer1/time-base/RTC. Bits 3 and 7 of register 1 always read 0, so a written value reads back masked with 0x77.
- R3: An active edge on an external pin sets its flag on the third rising clock edge after the pin changes. With the default build, ext0 is active on its falling edge and ext1 on its rising edge. The opposite edge has no effect.
- R4: A one-cycle timer, time-base or RTC pulse sets its flag on the next clock edge, whether or not that source is enabled.
- R5: A maskable source is offered only when its flag, its enable and the global enable are all 1 and the stack level is below 8. The vector is 0x04 for ext0, 0x08 for ext1, 0x0C for timer0, 0x10 for timer1, 0x14 for time-base, 0x18 for RTC and 0x1C for conversion-done.
- R6: When several sources are eligible, the vector offered follows the priority conversion-done, ext0, ext1, timer0, timer1, time-base, RTC.
- R7: Accepting a maskable call clears that source's flag and the global enable. Every other flag is left as it was.
- R8: If hardware sets a flag in the same cycle that software writes 0 to it, the flag ends up 1.
- R9: A stack level of 8 or more blocks every maskable source. A pending maskable request is offered again as soon as the level drops below 8.
- R10: A falling edge of `adc_busy` while the conversion-done enable is 1 makes that source pending. It is offered whatever the global enable or stack level. Accepting it clears only the pending state and leaves the global enable unchanged. A falling edge while its enable is 0 is discarded.
- R11: The call stays offered until `call_ready` is sampled high with `call_valid`. Without acceptance, no flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_in | input | 2 | Asynchronous external interrupt pins |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| tbase_tick | input | 1 | Time-base tick pulse |
| rtc_tick | input | 1 | Real-time-clock tick pulse |
| adc_busy | input | 1 | Conversion in progress; a fall means done |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Register select, 0 or 1 |
| reg_wr_data | input | 8 | Register write data |
| reg0_q | output | 8 | Register 0 contents |
| reg1_q | output | 8 | Register 1 contents |
| stack_level | input | 4 | Return addresses currently stacked |
| call_valid | output | 1 | Call offered |
| call_ready | input | 1 | Core accepts the offered call |
| call_vector | output | 8 | Branch address of the offered call |

## Verification
Flags from the timers, the time-base, the RTC and conversion-done become visible one edge after their pulse or fall. External flags become visible three edges after the pin changes. Register writes show one edge later. `call_valid` and `call_vector` follow the flags and the stack level in the same cycle, with no register between them. Accepting a call clears its bits on the edge at which ready is sampled. The bench drives all inputs on the falling clock edge and samples either at the next falling edge or 1 ns after a level change. For the external pins it checks that the flag is still clear at the second falling edge and set at the third.

// File: rtl/irq_vec_pkg.sv
`timescale 1ns/1ps
package irq_vec_pkg;
  localparam int NSRC  = 7;   // index 0 is the non-maskable conversion-done source
  localparam int VEC_W = 8;

  typedef enum logic [2:0] {
    SRC_ADC = 3'd0, SRC_EXT0 = 3'd1, SRC_EXT1 = 3'd2, SRC_TMR0 = 3'd3,
    SRC_TMR1 = 3'd4, SRC_TBASE = 3'd5, SRC_RTC = 3'd6
  } irq_src_e;

  // Maskable source i branches to 4*i; conversion-done owns the top slot.
  function automatic logic [VEC_W-1:0] src_vector(input int idx);
    if (idx == int'(SRC_ADC)) return VEC_W'(8'h1C);
    return VEC_W'(4 * idx);
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
`timescale 1ns/1ps
module irq_edge_sync #(
  parameter int STAGES  = 2,
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= {STAGES{FALLING}};
      last_q <= FALLING;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      last_q <= sync_q[STAGES-1];
    end
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_o = last_q & ~sync_q[STAGES-1];
    end else begin : g_rise
      assign edge_o = ~last_q & sync_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/irq_prio_arb.sv
`timescale 1ns/1ps
module irq_prio_arb
  import irq_vec_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [N-1:0]     grant,
  output logic [VEC_W-1:0] vec
);
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    vec   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        found    = 1'b1;
        grant[i] = 1'b1;
        vec      = src_vector(i);
      end
    end
    any = found;
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int       STACK_DEPTH = 8,
  parameter int       SYNC_STAGES = 2,
  parameter bit [1:0] EXT_FALL    = 2'b01,
  localparam int      LVL_W       = $clog2(STACK_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ext_in,
  input  logic             tmr0_ovf,
  input  logic             tmr1_ovf,
  input  logic             tbase_tick,
  input  logic             rtc_tick,
  input  logic             adc_busy,
  input  logic             reg_wr_en,
  input  logic             reg_wr_sel,
  input  logic [7:0]       reg_wr_data,
  output logic [7:0]       reg0_q,
  output logic [7:0]       reg1_q,
  input  logic [LVL_W-1:0] stack_level,
  output logic             call_valid,
  input  logic             call_ready,
  output logic [VEC_W-1:0] call_vector
);
  logic            gie_q, gie_n;
  logic [NSRC-1:0] en_q, en_n;      // en[0] is the conversion-done enable
  logic [NSRC-1:1] flg_q, flg_n;
  logic            adc_pend_q, adc_pend_n;
  logic            adc_prev_q;
  logic [1:0]      ext_edge;
  logic [NSRC-1:0] hw_set, req, grant;
  logic            stack_full, accept;

  for (genvar k = 0; k < 2; k++) begin : g_ext
    irq_edge_sync #(.STAGES(SYNC_STAGES), .FALLING(EXT_FALL[k])) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(ext_in[k]), .edge_o(ext_edge[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) adc_prev_q <= 1'b0;
    else        adc_prev_q <= adc_busy;
  end

  assign hw_set = {rtc_tick, tbase_tick, tmr1_ovf, tmr0_ovf, ext_edge,
                   adc_prev_q & ~adc_busy & en_q[SRC_ADC]};

  assign stack_full = stack_level >= LVL_W'(STACK_DEPTH);

  always_comb begin
    req[SRC_ADC] = adc_pend_q & en_q[SRC_ADC];
    for (int i = 1; i < NSRC; i++)
      req[i] = gie_q & en_q[i] & flg_q[i] & ~stack_full;
  end

  irq_prio_arb #(.N(NSRC)) u_arb (
    .req(req), .any(call_valid), .grant(grant), .vec(call_vector)
  );

  assign accept = call_valid & call_ready;

  // Register view: sources 1..3 in register 0, sources 4..6 in register 1.
  always_comb begin
    reg0_q    = '0;
    reg1_q    = '0;
    reg0_q[0] = gie_q;
    reg0_q[7] = en_q[SRC_ADC];
    for (int i = 1; i <= 3; i++) begin
      reg0_q[i]     = en_q[i];
      reg0_q[i + 3] = flg_q[i];
    end
    for (int i = 4; i < NSRC; i++) begin
      reg1_q[i - 4] = en_q[i];
      reg1_q[i]     = flg_q[i];
    end
  end

  always_comb begin
    gie_n      = gie_q;
    en_n       = en_q;
    flg_n      = flg_q;
    adc_pend_n = adc_pend_q;
    if (reg_wr_en && !reg_wr_sel) begin
      gie_n         = reg_wr_data[0];
      en_n[SRC_ADC] = reg_wr_data[7];
      for (int i = 1; i <= 3; i++) begin
        en_n[i]  = reg_wr_data[i];
        flg_n[i] = reg_wr_data[i + 3];
      end
    end
    if (reg_wr_en && reg_wr_sel) begin
      for (int i = 4; i < NSRC; i++) begin
        en_n[i]  = reg_wr_data[i - 4];
        flg_n[i] = reg_wr_data[i];
      end
    end
    if (accept) begin
      if (|grant[NSRC-1:1]) gie_n = 1'b0;
      flg_n      = flg_n & ~grant[NSRC-1:1];
      adc_pend_n = adc_pend_n & ~grant[SRC_ADC];
    end
    flg_n      = flg_n | hw_set[NSRC-1:1];
    adc_pend_n = adc_pend_n | hw_set[SRC_ADC];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q      <= 1'b0;
      en_q       <= '0;
      flg_q      <= '0;
      adc_pend_q <= 1'b0;
    end else begin
      gie_q      <= gie_n;
      en_q       <= en_n;
      flg_q      <= flg_n;
      adc_pend_q <= adc_pend_n;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
`timescale 1ns/1ps
module irq_vector_ctrl_chk #(
  parameter int STACK_DEPTH = 8,
  parameter int LVL_W       = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic [7:0]       reg0_q,
  input logic [7:0]       reg1_q,
  input logic [LVL_W-1:0] stack_level,
  input logic             call_valid,
  input logic             call_ready,
  input logic [7:0]       call_vector
);
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg1_q[3] && !reg1_q[7]);

  p_gie_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid && call_vector != 8'h1C |-> reg0_q[0]);

  p_accept_clears_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid && call_ready && call_vector != 8'h1C |=> !reg0_q[0]);

  p_full_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid && stack_level >= LVL_W'(STACK_DEPTH) |-> call_vector == 8'h1C);

  p_adc_keeps_gie_r10: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid && call_ready && call_vector == 8'h1C && !reg_wr_en
    |=> reg0_q[0] == $past(reg0_q[0]));

  p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(call_valid && call_ready) && !reg_wr_en
    |=> ((reg0_q[6:4] & $past(reg0_q[6:4])) == $past(reg0_q[6:4]))
     && ((reg1_q[6:4] & $past(reg1_q[6:4])) == $past(reg1_q[6:4])));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.STACK_DEPTH(STACK_DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg0_q(reg0_q), .reg1_q(reg1_q),
  .stack_level(stack_level), .call_valid(call_valid), .call_ready(call_ready),
  .call_vector(call_vector)
);

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, tmr0_ovf, tmr1_ovf, tbase_tick, rtc_tick, adc_busy;
  logic [1:0] ext_in;
  logic       reg_wr_en, reg_wr_sel, call_ready, call_valid;
  logic [7:0] reg_wr_data, reg0_q, reg1_q, call_vector;
  logic [3:0] stack_level;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
    .tbase_tick(tbase_tick), .rtc_tick(rtc_tick), .adc_busy(adc_busy),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .reg0_q(reg0_q), .reg1_q(reg1_q), .stack_level(stack_level),
    .call_valid(call_valid), .call_ready(call_ready), .call_vector(call_vector)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
    tick(1);
    reg_wr_en = 1'b0;
  endtask

  task automatic accept();
    call_ready = 1'b1;
    tick(1);
    call_ready = 1'b0;
  endtask

  // Register images per R2; index 0 of en is the conversion-done enable.
  function automatic logic [7:0] mk_r0(input logic [6:0] en, input logic [6:0] fl, input bit g);
    return {en[0], fl[3], fl[2], fl[1], en[3], en[2], en[1], g};
  endfunction
  function automatic logic [7:0] mk_r1(input logic [6:0] en, input logic [6:0] fl);
    return {1'b0, fl[6], fl[5], fl[4], 1'b0, en[6], en[5], en[4]};
  endfunction

  task automatic apply(input logic [6:0] en, input logic [6:0] fl, input bit g);
    wr(1'b1, mk_r1(en, fl));
    wr(1'b0, mk_r0(en, fl, g));
  endtask

  function automatic int flag_of(input int s);
    return (s <= 3) ? int'(reg0_q[s + 3]) : int'(reg1_q[s]);
  endfunction

  task automatic pulse(input int which);
    case (which)
      3: tmr0_ovf = 1'b1; 4: tmr1_ovf = 1'b1; 5: tbase_tick = 1'b1; default: rtc_tick = 1'b1;
    endcase
    tick(1);
    tmr0_ovf = 1'b0; tmr1_ovf = 1'b0; tbase_tick = 1'b0; rtc_tick = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    rst_n = 1'b0; ext_in = 2'b01; tmr0_ovf = 0; tmr1_ovf = 0; tbase_tick = 0; rtc_tick = 0;
    adc_busy = 0; reg_wr_en = 0; reg_wr_sel = 0; reg_wr_data = 0; call_ready = 0; stack_level = 0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    eq("R1 reg0 after reset", reg0_q, 0);
    eq("R1 reg1 after reset", reg1_q, 0);
    eq("R1 call_valid after reset", call_valid, 0);

    // R2: every write value through both registers
    for (int d = 0; d < 256; d++) begin
      wr(1'b1, 8'(d));
      eq("R2 reg1 readback", reg1_q, d & 8'h77);
      wr(1'b0, 8'(d));
      eq("R2 reg0 readback", reg0_q, d);
    end
    wr(1'b0, 8'h00); wr(1'b1, 8'h00);

    // R4: pulses set flags with enables off; nothing offered (R5)
    for (int s = 3; s <= 6; s++) begin
      pulse(s);
      eq("R4 pulse sets flag", flag_of(s), 1);
      eq("R5 no call without enable", call_valid, 0);
      wr(1'b0, 8'h00); wr(1'b1, 8'h00);
    end

    // R3: ext0 falling active, ext1 rising active
    ext_in[0] = 1'b0;
    tick(2); eq("R3 ext0 flag not before third edge", reg0_q[4], 0);
    tick(1); eq("R3 ext0 flag on third edge", reg0_q[4], 1);
    wr(1'b0, 8'h00);
    ext_in[0] = 1'b1; tick(4);
    eq("R3 ext0 rising ignored", reg0_q[4], 0);
    ext_in[1] = 1'b1;
    tick(2); eq("R3 ext1 flag not before third edge", reg0_q[5], 0);
    tick(1); eq("R3 ext1 flag on third edge", reg0_q[5], 1);
    wr(1'b0, 8'h00);
    ext_in[1] = 1'b0; tick(4);
    eq("R3 ext1 falling ignored", reg0_q[5], 0);

    // R5/R7/R11: each maskable source against every gate combination
    for (int s = 1; s <= 6; s++) begin
      for (int g = 0; g < 2; g++) begin
        for (int e = 0; e < 2; e++) begin
          apply(e ? 7'(1 << s) : 7'h00, 7'(1 << s), g[0]);
          eq("R5 gating", call_valid, g & e);
          if (g == 1 && e == 1) begin
            eq("R5 vector", call_vector, 4 * s);
            tick(3);
            eq("R11 held without ready", call_valid, 1);
            eq("R11 flag kept without ready", flag_of(s), 1);
            accept();
            eq("R7 flag cleared on accept", flag_of(s), 0);
            eq("R7 global enable cleared", reg0_q[0], 0);
            eq("R7 nothing offered after accept", call_valid, 0);
          end
          wr(1'b0, 8'h00); wr(1'b1, 8'h00);
        end
      end
    end

    // R6: every subset of maskable flags, all enabled
    for (int m = 1; m < 64; m++) begin
      int low;
      low = 0;
      for (int s = 6; s >= 1; s--) if (m[s-1]) low = s;
      apply(7'h7E, 7'(m << 1), 1'b1);
      eq("R6 priority vector", call_vector, 4 * low);
    end

    // R7: other flags survive an accept
    apply(7'h7E, 7'b0010010, 1'b1);
    accept();
    eq("R7 accepted flag cleared", flag_of(1), 0);
    eq("R7 other flag kept", flag_of(4), 1);
    eq("R7 global enable cleared", reg0_q[0], 0);
    wr(1'b0, reg0_q | 8'h01);
    eq("R7 next source after re-enable", call_vector, 8'h10);
    wr(1'b0, 8'h00); wr(1'b1, 8'h00);

    // R8: hardware set beats software clear
    apply(7'h00, 7'b0001000, 1'b0);
    reg_wr_en = 1'b1; reg_wr_sel = 1'b0; reg_wr_data = 8'h00; tmr0_ovf = 1'b1;
    tick(1);
    reg_wr_en = 1'b0; tmr0_ovf = 1'b0;
    eq("R8 set wins over write of 0", reg0_q[6], 1);
    wr(1'b0, 8'h00);
    eq("R8 plain write of 0 clears", reg0_q[6], 0);

    // R9: full stack blocks, release resumes
    apply(7'h7E, 7'b0000010, 1'b1);
    stack_level = 4'd8; #1;
    eq("R9 full stack blocks", call_valid, 0);
    tick(2);
    eq("R9 still blocked", call_valid, 0);
    stack_level = 4'd7; #1;
    eq("R9 resumes below full", call_valid, 1);
    eq("R9 resumed vector", call_vector, 8'h04);
    stack_level = 4'd0;
    tick(1);
    wr(1'b0, 8'h00); wr(1'b1, 8'h00);

    // R10: conversion-done with global enable off and stack full
    wr(1'b0, 8'h80);
    adc_busy = 1'b1; tick(2);
    adc_busy = 1'b0; stack_level = 4'd8;
    tick(1);
    eq("R10 offered with gie off and full stack", call_valid, 1);
    eq("R10 vector", call_vector, 8'h1C);
    tick(2);
    eq("R11 conversion-done held", call_valid, 1);
    accept();
    eq("R10 pending cleared", call_valid, 0);
    eq("R10 registers untouched", reg0_q, 8'h80);
    stack_level = 4'd0;

    // R6/R10: conversion-done beats ext0 and keeps the global enable
    apply(7'b0000011, 7'b0000010, 1'b1);
    eq("R5 ext0 offered", call_vector, 8'h04);
    adc_busy = 1'b1; tick(2);
    adc_busy = 1'b0; tick(1);
    eq("R6 conversion-done first", call_vector, 8'h1C);
    accept();
    eq("R10 gie kept", reg0_q[0], 1);
    eq("R10 ext0 next", call_vector, 8'h04);
    accept();
    eq("R7 gie cleared by ext0", reg0_q[0], 0);

    // R10: edge with enable clear is discarded
    wr(1'b0, 8'h00);
    adc_busy = 1'b1; tick(2);
    adc_busy = 1'b0; tick(1);
    eq("R10 disabled edge not offered", call_valid, 0);
    wr(1'b0, 8'h80);
    eq("R10 disabled edge discarded", call_valid, 0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, requirements R1 to R11 incomplete");
      summary();
      $finish;
    end
  end
endmodule